// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupts for a small microcontroller core. Four sources feed it, ranked from most to least urgent: a USB event, a timer/event counter 0 overflow, a timer/event counter 1 overflow and an SPI transfer event. Each source has a latched pending flag and its own enable bit. A single master enable gates every source. A peripheral event always records its flag, even while the source or the master enable is off. The request then waits until it may be served.

At an instruction boundary the block may accept the most urgent request that is pending and enabled. It does this only when the master enable is on and the hardware stack has room. Acceptance is a one-cycle pulse. It tells the core to push the program counter and to jump to the vector of the winning source. On the next clock the block clears the master enable and the flag of the served source by itself. Further interrupts therefore stay blocked until software sets the master enable again, either inside the service routine to allow nesting or through the return-from-interrupt strobe. The strobe sets the master enable back to 1 in the cycle the core pops the program counter.

Software can write the flags, the enables and the master enable. An 8-bit read view shows the control register of the lowest-priority (SPI) source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all pending flags, all enables and the master enable are 0, and no acceptance is signalled.
- R2: A peripheral event on a source sets that source's flag on the next clock, whatever the enables and the master enable hold.
- R3: `take` is high only when all four conditions hold in that cycle: the master enable is 1, `at_boundary` is 1, `stack_full` is 0, and at least one source has both its flag and its enable set.
- R4: Priority is fixed: index 0 (USB) is highest, then 1 (timer 0), then 2 (timer 1), then 3 (SPI). On `take`, `take_id` is the lowest eligible index and `vec_addr` is 0x04 + 4 * `take_id` (0x04, 0x08, 0x0C, 0x10).
- R5: After a `take` the master enable reads 0 on the next clock.
- R6: After a `take` the flag of the served source reads 0 on the next clock, unless a peripheral event or a software set hit that flag in the same cycle.
- R7: While `stack_full` is 1, no request is accepted, even one that is pending and enabled.
- R8: A return strobe without a `take` in the same cycle sets the master enable to 1 on the next clock. The order of precedence for the master enable is: `take` clears it, then the return strobe sets it, then a software write applies.
- R9: A software write with mask bit set loads the flag, enable or master-enable value given. A peripheral event beats a software clear of the same flag in the same cycle.
- R10: `spi_ctl_rd` shows the SPI (index 3) flag at bit 4 and the SPI enable at bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| src_evt | input | 4 | Peripheral event pulses, bit 0 = USB ... bit 3 = SPI |
| sw_we_flag | input | 4 | Software write mask for flags |
| sw_flag_val | input | 4 | Software flag values |
| sw_we_en | input | 4 | Software write mask for enables |
| sw_en_val | input | 4 | Software enable values |
| sw_we_gie | input | 1 | Software write strobe for the master enable |
| sw_gie_val | input | 1 | Software master enable value |
| stack_full | input | 1 | Hardware stack has no free entry |
| at_boundary | input | 1 | Core is at an instruction boundary |
| reti_strobe | input | 1 | Return from interrupt: core pops the PC this cycle |
| take | output | 1 | Acceptance pulse; the core pushes the PC and jumps |
| take_id | output | 2 | Index of the accepted source |
| vec_addr | output | 8 | Vector address of the accepted source |
| flags_q | output | 4 | Pending flags |
| en_q | output | 4 | Source enables |
| gie_q | output | 1 | Master enable |
| spi_ctl_rd | output | 8 | SPI control register read view |

## Verification
The bench builds the block with its defaults: four sources, vector base 0x04 and vector step 4 in an 8-bit address. With these values every vector is reachable and can be checked exactly, including 0x10 for the lowest source. The SPI view lines up with source index 3. With only four sources, random event and enable masks hit every pattern of ties between the sources. The bench also stresses the collision of acceptance, return strobe and software writes on the master enable in the same cycle, and of events with clears on the same flag.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  // master-enable next-state origin, in precedence order
  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_TAKE = 2'd1,
    GIE_RET  = 2'd2,
    GIE_SW   = 2'd3
  } gie_src_e;

  // vector address of source index idx
  function automatic int unsigned vec_calc(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_set,
  input  logic [N_SRC-1:0] sw_we,
  input  logic [N_SRC-1:0] sw_val,
  input  logic [N_SRC-1:0] svc_clr,
  output logic [N_SRC-1:0] flags_q
);
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_flag
      logic set_any;
      logic clr_any;
      // a set from the peripheral or from software wins over any clear
      assign set_any = hw_set[g] | (sw_we[g] & sw_val[g]);
      assign clr_any = svc_clr[g] | (sw_we[g] & ~sw_val[g]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags_q[g] <= 1'b0;
        else if (set_any) flags_q[g] <= 1'b1;
        else if (clr_any) flags_q[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int N_SRC    = 4,
  parameter int IDW      = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [N_SRC-1:0] elig,
  output logic             any,
  output logic [IDW-1:0]   win_id,
  output logic [N_SRC-1:0] win_oh,
  output logic [VEC_W-1:0] vec
);
  import irq_pkg::*;

  assign any = |elig;

  // lowest index wins: scan from the bottom of the ranking upward
  always_comb begin
    win_id = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) win_id = IDW'(i);
    end
  end

  always_comb begin
    win_oh = '0;
    if (any) win_oh[win_id] = 1'b1;
  end

  assign vec = VEC_W'(vec_calc(VEC_BASE, VEC_STEP, 32'(win_id)));
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic any,
  input  logic stack_full,
  input  logic at_boundary,
  input  logic reti_strobe,
  input  logic sw_we_gie,
  input  logic sw_gie_val,
  output logic take,
  output logic gie_q
);
  import irq_pkg::*;

  gie_src_e gie_src;
  logic     gie_nxt;

  assign take = gie_q & any & ~stack_full & at_boundary;

  always_comb begin
    if (take)             gie_src = GIE_TAKE;
    else if (reti_strobe) gie_src = GIE_RET;
    else if (sw_we_gie)   gie_src = GIE_SW;
    else                  gie_src = GIE_HOLD;
  end

  always_comb begin
    unique case (gie_src)
      GIE_TAKE: gie_nxt = 1'b0;
      GIE_RET:  gie_nxt = 1'b1;
      GIE_SW:   gie_nxt = sw_gie_val;
      default:  gie_nxt = gie_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int N_SRC    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IDW     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int SPI_IDX = N_SRC - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] sw_we_flag,
  input  logic [N_SRC-1:0] sw_flag_val,
  input  logic [N_SRC-1:0] sw_we_en,
  input  logic [N_SRC-1:0] sw_en_val,
  input  logic             sw_we_gie,
  input  logic             sw_gie_val,
  input  logic             stack_full,
  input  logic             at_boundary,
  input  logic             reti_strobe,
  output logic             take,
  output logic [IDW-1:0]   take_id,
  output logic [VEC_W-1:0] vec_addr,
  output logic [N_SRC-1:0] flags_q,
  output logic [N_SRC-1:0] en_q,
  output logic             gie_q,
  output logic [7:0]       spi_ctl_rd
);
  // named internal events, brought out for the checker
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] win_oh;
  logic [N_SRC-1:0] svc_clr;
  logic             any_elig;

  assign elig    = flags_q & en_q;
  assign svc_clr = take ? win_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q & ~sw_we_en) | (sw_we_en & sw_en_val);
  end

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (src_evt),
    .sw_we   (sw_we_flag),
    .sw_val  (sw_flag_val),
    .svc_clr (svc_clr),
    .flags_q (flags_q)
  );

  irq_arbiter #(
    .N_SRC(N_SRC), .IDW(IDW), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .elig   (elig),
    .any    (any_elig),
    .win_id (take_id),
    .win_oh (win_oh),
    .vec    (vec_addr)
  );

  irq_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .any         (any_elig),
    .stack_full  (stack_full),
    .at_boundary (at_boundary),
    .reti_strobe (reti_strobe),
    .sw_we_gie   (sw_we_gie),
    .sw_gie_val  (sw_gie_val),
    .take        (take),
    .gie_q       (gie_q)
  );

  assign spi_ctl_rd = {3'b000, flags_q[SPI_IDX], 3'b000, en_q[SPI_IDX]};
endmodule

// File: rtl/irq_ctrl_checker.sv
`timescale 1ns/1ps
module irq_ctrl_checker #(
  parameter int N_SRC = 4,
  parameter int IDW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_evt,
  input logic [N_SRC-1:0] sw_we_flag,
  input logic [N_SRC-1:0] sw_flag_val,
  input logic             stack_full,
  input logic             at_boundary,
  input logic             reti_strobe,
  input logic             take,
  input logic [IDW-1:0]   take_id,
  input logic [N_SRC-1:0] flags_q,
  input logic [N_SRC-1:0] en_q,
  input logic             gie_q,
  input logic [N_SRC-1:0] win_oh,
  input logic [7:0]       spi_ctl_rd
);
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flags_q & $past(src_evt)) == $past(src_evt)));

  a_r3_take_legal: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gie_q && at_boundary && flags_q[take_id] && en_q[take_id]));

  a_r4_no_higher_pending: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((flags_q & en_q & ((N_SRC'(1) << take_id) - N_SRC'(1))) == '0));

  a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  a_r5_gie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);

  a_r6_flag_served: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !src_evt[take_id] && !(sw_we_flag[take_id] && sw_flag_val[take_id]))
      |=> !flags_q[$past(take_id)]);

  a_r7_stack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !take);

  a_r8_return_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_strobe && !take) |=> gie_q);

  a_r10_view_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_ctl_rd & 8'hEE) == 8'h00);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.N_SRC(N_SRC), .IDW(IDW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_evt     (src_evt),
  .sw_we_flag  (sw_we_flag),
  .sw_flag_val (sw_flag_val),
  .stack_full  (stack_full),
  .at_boundary (at_boundary),
  .reti_strobe (reti_strobe),
  .take        (take),
  .take_id     (take_id),
  .flags_q     (flags_q),
  .en_q        (en_q),
  .gie_q       (gie_q),
  .win_oh      (win_oh),
  .spi_ctl_rd  (spi_ctl_rd)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_evt = '0, sw_we_flag = '0, sw_flag_val = '0, sw_we_en = '0, sw_en_val = '0;
  logic       sw_we_gie = 1'b0, sw_gie_val = 1'b0, stack_full = 1'b0, at_boundary = 1'b0, reti_strobe = 1'b0;
  logic       take;
  logic [1:0] take_id;
  logic [7:0] vec_addr;
  logic [3:0] flags_q, en_q;
  logic       gie_q;
  logic [7:0] spi_ctl_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [3:0] m_flags = '0, m_en = '0;
  logic       m_gie = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .sw_we_flag(sw_we_flag),
    .sw_flag_val(sw_flag_val), .sw_we_en(sw_we_en), .sw_en_val(sw_en_val),
    .sw_we_gie(sw_we_gie), .sw_gie_val(sw_gie_val), .stack_full(stack_full),
    .at_boundary(at_boundary), .reti_strobe(reti_strobe), .take(take),
    .take_id(take_id), .vec_addr(vec_addr), .flags_q(flags_q), .en_q(en_q),
    .gie_q(gie_q), .spi_ctl_rd(spi_ctl_rd)
  );

  function automatic int exp_winner(input logic [3:0] elig);
    for (int i = 0; i < 4; i++) if (elig[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_vector(input int idx);
    return 8'(4 * (idx + 1));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] ev, input logic [3:0] wf, input logic [3:0] vf,
                      input logic [3:0] we, input logic [3:0] ve, input logic wg,
                      input logic vg, input logic sf, input logic bd, input logic rt);
    logic       t_exp;
    int         w;
    logic [3:0] clr;
    @(negedge clk);
    src_evt = ev; sw_we_flag = wf; sw_flag_val = vf; sw_we_en = we; sw_en_val = ve;
    sw_we_gie = wg; sw_gie_val = vg; stack_full = sf; at_boundary = bd; reti_strobe = rt;
    #1;
    check("R9 R2 R6 flags", 32'(flags_q), 32'(m_flags));
    check("R9 enables", 32'(en_q), 32'(m_en));
    check("R5 R8 R9 master enable", 32'(gie_q), 32'(m_gie));
    check("R10 spi view", 32'(spi_ctl_rd), 32'({3'b0, m_flags[3], 3'b0, m_en[3]}));
    w = exp_winner(m_flags & m_en);
    t_exp = m_gie && bd && !sf && (w >= 0);
    check("R3 R7 take", 32'(take), 32'(t_exp));
    if (t_exp) begin
      check("R4 take_id", 32'(take_id), 32'(w));
      check("R4 vec_addr", 32'(vec_addr), 32'(exp_vector(w)));
    end
    clr = t_exp ? 4'(1 << w) : 4'b0;
    m_flags = ev | (wf & vf) | (m_flags & ~(clr | (wf & ~vf)));
    m_en    = (m_en & ~we) | (we & ve);
    m_gie   = t_exp ? 1'b0 : (rt ? 1'b1 : (wg ? vg : m_gie));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flags", 32'(flags_q), 32'h0);
    check("R1 enables", 32'(en_q), 32'h0);
    check("R1 master enable", 32'(gie_q), 32'h0);
    check("R1 take", 32'(take), 32'h0);
    check("R1 spi view", 32'(spi_ctl_rd), 32'h0);
    rst_n = 1'b1;
    // R2: events recorded with everything disabled
    step(4'hF, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // enable all sources and the master enable, with stack full (R7)
    step(0, 0, 0, 4'hF, 4'hF, 1, 1, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    // not at boundary: no take
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // take USB (vector 0x04), then blocked by cleared master enable (R5)
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // nesting: software sets master enable, then timer 0 wins (0x08)
    step(0, 0, 0, 0, 0, 1, 1, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R8: return strobe re-enables, timer 1 wins (0x0C)
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R9: SPI event beats software clear of SPI flag
    step(4'h8, 4'h8, 4'h0, 0, 0, 0, 0, 0, 0, 0);
    // R6: take SPI (0x10) while a new SPI event arrives: flag stays set
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(4'h8, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // take, return strobe and software clear all at once (precedence R8)
    step(0, 0, 0, 0, 0, 1, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      step(4'($urandom & $urandom & $urandom),
           4'($urandom & $urandom & $urandom & $urandom),
           4'($urandom),
           4'($urandom & $urandom & $urandom & $urandom),
           4'($urandom | $urandom),
           ($urandom % 6) == 0,
           ($urandom % 4) != 0,
           ($urandom % 4) == 0,
           ($urandom % 4) != 0,
           ($urandom % 12) == 0);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule